// File: doc/BRIEF.md
# Multichannel TDM Serial Transmitter

This block serializes per-channel words onto one time-division multiplexed serial line. One core clock cycle is one bit time. A frame is a programmable number of slots of equal, programmable length, from 8 to 32 bits. Each slot is sent most significant bit first. Two mask vectors, each one bit per slot, set which slots carry data and which of those carry a mu-law code instead of the linear word. The masks are looked up afresh at every slot boundary in every frame, so a slot's settings do not depend on where it sits in the frame.

There are two frame-sync styles. In pulse style, a one-bit-wide high pulse comes in the bit before slot 0. In split style, the bit timing is the same, but the sync line is a level. It is low across the first half of the slots and high across the second half, so each half can carry many channels. Words arrive on a valid/ready handshake, one per active slot.

After reset the sequencer sits on a single lead-in bit. This gives the first frame the same one-bit sync lead as every later frame. Clearing `run` freezes the sequencer. If no word is waiting when an active slot is loaded, the slot is sent as zeros and a sticky flag is raised.

Top module: `tdm_tx`

## Requirements
- R1: After reset the block is on the lead-in bit before slot 0, with `sd_oe`, `sd_out`, `in_ready` and `underflow` all low. In pulse style `fs_out` is high there.
- R2: Each active slot sends the low `word_len` bits of the accepted word, most significant bit first, one bit per cycle while `run` is high. The word is taken on the cycle where `in_ready` and `in_valid` are both high. `in_ready` rises only in the last bit before an active slot.
- R3: An inactive slot still takes its `word_len` bit times, but no word is taken for it and `sd_oe` and `sd_out` stay low. A set compand bit on an inactive slot has no effect.
- R4: With `packed_mode` = 0, `fs_out` is high for exactly one bit: the bit just before the first bit of slot 0, in every frame.
- R5: With `packed_mode` = 1, `fs_out` is low for slots 0 to `slot_count`/2 − 1 and high for the remaining slots. It changes level during the last bit before the first slot of each half.
- R6: A slot that is both active and companded sends, in its first 8 bit times, the mu-law code (bias 0x84, 3-bit segment, 4-bit step, then all bits inverted) of bits 31..16 of the word left-aligned to 32 bits. Its remaining bits are zero.
- R7: Companding of any slot, including the first active slot when it is not slot 0, is applied in every frame and not only in the first.
- R8: If `in_valid` is low when an active slot is loaded, that slot is sent as zeros with `sd_oe` high, and `underflow` goes high and stays high until reset.
- R9: While `run` is low, the position does not advance, `sd_out` and `sd_oe` hold, and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one bit time per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Advance one bit per cycle when high |
| packed_mode | input | 1 | 0: pulse frame sync, 1: split-frame level sync |
| slot_count | input | 8 | Slots per frame, 1 to 128 |
| word_len | input | 6 | Bits per slot, 8 to 32 |
| active_mask | input | 128 | One bit per slot: slot carries data |
| compand_mask | input | 128 | One bit per slot: send mu-law code |
| in_valid | input | 1 | A word is offered |
| in_data | input | 32 | Offered word, right-justified |
| in_ready | output | 1 | Word taken at this clock edge if valid |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data drive enable |
| fs_out | output | 1 | Frame sync |
| underflow | output | 1 | Sticky: an active slot started with no word |

## Verification
At the end of one slot, the sequencer's advance, the next slot's mask lookup, the word handshake and the frame-sync edge all land on the same edge. The underflow decision lands there as well. The bench provokes this with a sparse active mask whose first active slot is slot 2 and is companded. Slot 5 is companded too, and the last slot wraps straight into the frame sync, so compand lookup, handshake and wrap fall in the same cycle over three frames. A further run with too few words forces handshake failure onto the same boundary. Each sampled bit, along with `sd_oe` and `fs_out`, is compared with a stream the bench builds from slot position, masks and a separately written mu-law encoder.

// File: rtl/tdm_tx_pkg.sv
`timescale 1ns/1ps
package tdm_tx_pkg;

  // mu-law code of a signed 16-bit sample: bias, segment search, step, invert
  function automatic logic [7:0] mulaw_code(input logic [15:0] smp);
    logic       sgn;
    logic [15:0] mag;
    logic [2:0] seg;
    logic [3:0] stp;
    sgn = smp[15];
    mag = sgn ? (~smp + 16'd1) : smp;
    if (mag > 16'd32635) mag = 16'd32635;
    mag = mag + 16'h0084;
    casez (mag[14:7])
      8'b1???????: seg = 3'd7;
      8'b01??????: seg = 3'd6;
      8'b001?????: seg = 3'd5;
      8'b0001????: seg = 3'd4;
      8'b00001???: seg = 3'd3;
      8'b000001??: seg = 3'd2;
      8'b0000001?: seg = 3'd1;
      default:     seg = 3'd0;
    endcase
    stp = 4'(mag >> (5'(seg) + 5'd3));
    return ~{sgn, seg, stp};
  endfunction

  // place a right-justified word of len bits at the top of a 32-bit field
  function automatic logic [31:0] left_align(input logic [31:0] w, input logic [5:0] len);
    return w << (6'd32 - len);
  endfunction

endpackage

// File: rtl/tdm_tx_seq.sv
`timescale 1ns/1ps
module tdm_tx_seq #(
  parameter int MAX_SLOTS = 128,
  parameter int MAX_BITS  = 32,
  localparam int SI_W  = $clog2(MAX_SLOTS),
  localparam int BI_W  = $clog2(MAX_BITS),
  localparam int SC_W  = $clog2(MAX_SLOTS + 1),
  localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             packed_mode,
  input  logic [SC_W-1:0]  slot_count,
  input  logic [LEN_W-1:0] word_len,
  output logic [SI_W-1:0]  cur_slot,
  output logic [SI_W-1:0]  next_slot,
  output logic             lead,
  output logic             slot_end,
  output logic             fs
);
  logic [BI_W-1:0] cur_bit;
  logic            last_slot;
  logic [SI_W-1:0] view_slot;
  logic [SC_W-1:0] half;

  assign last_slot = SC_W'(cur_slot) == slot_count - SC_W'(1);
  assign slot_end  = lead || (LEN_W'(cur_bit) == word_len - LEN_W'(1));
  assign next_slot = (lead || last_slot) ? '0 : cur_slot + SI_W'(1);
  assign half      = slot_count >> 1;
  // the sync reflects the position of the bit that follows
  assign view_slot = slot_end ? next_slot : cur_slot;
  assign fs        = packed_mode ? (SC_W'(view_slot) >= half)
                                 : (slot_end && next_slot == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead     <= 1'b1;
      cur_slot <= '0;
      cur_bit  <= '0;
    end else if (run) begin
      if (slot_end) begin
        lead     <= 1'b0;
        cur_slot <= next_slot;
        cur_bit  <= '0;
      end else begin
        cur_bit  <= cur_bit + BI_W'(1);
      end
    end
  end

  p_slot_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (SC_W'(cur_slot) < slot_count));
  p_pulse_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && !packed_mode && fs |=> !fs);
  p_level_moves_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run && packed_mode |=> $stable(fs) || slot_end);
endmodule

// File: rtl/tdm_tx_fmt.sv
`timescale 1ns/1ps
module tdm_tx_fmt #(
  parameter int MAX_BITS = 32,
  localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
  input  logic [MAX_BITS-1:0] word,
  input  logic [LEN_W-1:0]    word_len,
  input  logic                compand,
  output logic [MAX_BITS-1:0] field
);
  import tdm_tx_pkg::*;
  logic [31:0] aligned;
  logic [7:0]  code;

  assign aligned = left_align(32'(word), 6'(word_len));
  assign code    = mulaw_code(aligned[31:16]);
  assign field   = compand ? MAX_BITS'({code, 24'd0}) : MAX_BITS'(aligned);
endmodule

// File: rtl/tdm_tx.sv
`timescale 1ns/1ps
module tdm_tx #(
  parameter int MAX_SLOTS = 128,
  parameter int MAX_BITS  = 32,
  localparam int SI_W  = $clog2(MAX_SLOTS),
  localparam int SC_W  = $clog2(MAX_SLOTS + 1),
  localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 packed_mode,
  input  logic [SC_W-1:0]      slot_count,
  input  logic [LEN_W-1:0]     word_len,
  input  logic [MAX_SLOTS-1:0] active_mask,
  input  logic [MAX_SLOTS-1:0] compand_mask,
  input  logic                 in_valid,
  input  logic [MAX_BITS-1:0]  in_data,
  output logic                 in_ready,
  output logic                 sd_out,
  output logic                 sd_oe,
  output logic                 fs_out,
  output logic                 underflow
);
  logic [SI_W-1:0]     cur_slot, next_slot;
  logic                lead, slot_end;
  logic                act_next, cmp_next;
  logic [MAX_BITS-1:0] field;
  logic [MAX_BITS-1:0] sh;
  logic                active_q;
  logic                load_evt, starve_evt;

  tdm_tx_seq #(.MAX_SLOTS(MAX_SLOTS), .MAX_BITS(MAX_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .packed_mode(packed_mode),
    .slot_count(slot_count), .word_len(word_len),
    .cur_slot(cur_slot), .next_slot(next_slot), .lead(lead),
    .slot_end(slot_end), .fs(fs_out)
  );

  // masks are indexed by the slot about to start, every frame
  assign act_next = active_mask[next_slot];
  assign cmp_next = compand_mask[next_slot];

  tdm_tx_fmt #(.MAX_BITS(MAX_BITS)) u_fmt (
    .word(in_data), .word_len(word_len), .compand(cmp_next), .field(field)
  );

  assign load_evt   = run && slot_end;
  assign in_ready   = load_evt && act_next;
  assign starve_evt = in_ready && !in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      active_q  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (load_evt) begin
        active_q <= act_next;
        sh       <= (act_next && in_valid) ? field : '0;
      end else if (run) begin
        sh <= sh << 1;
      end
      if (starve_evt) underflow <= 1'b1;
    end
  end

  assign sd_out = active_q && sh[MAX_BITS-1];
  assign sd_oe  = active_q && !lead;

  p_take_then_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && in_valid |=> sd_oe);
  p_quiet_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out);
  p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  p_hold_when_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(sd_out) && $stable(sd_oe));
endmodule

// File: tb/tdm_tx_test.sv
`timescale 1ns/1ps
module tdm_tx_test;
  logic         clk = 1'b0;
  logic         rst_n, run, packed_mode, in_valid;
  logic [7:0]   slot_count;
  logic [5:0]   word_len;
  logic [127:0] active_mask, compand_mask;
  logic [31:0]  in_data;
  logic         in_ready, sd_out, sd_oe, fs_out, underflow;
  int           n_chk = 0;
  int           n_bad = 0;

  always #5 clk = ~clk;

  tdm_tx uut (
    .clk(clk), .rst_n(rst_n), .run(run), .packed_mode(packed_mode),
    .slot_count(slot_count), .word_len(word_len),
    .active_mask(active_mask), .compand_mask(compand_mask),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sd_out(sd_out), .sd_oe(sd_oe), .fs_out(fs_out), .underflow(underflow)
  );

  function automatic logic [31:0] wd(int n, int seed);
    return (32'(n) * 32'h9E3779B9 + 32'(seed) * 32'h7F4A7C15) ^ 32'(n << 11);
  endfunction

  // independent mu-law model using integer thresholds
  function automatic logic [7:0] ulaw(logic [15:0] s);
    int v, e, m;
    logic neg;
    v = int'($signed(s));
    neg = v < 0;
    if (neg) v = -v;
    if (v > 32635) v = 32635;
    v = v + 132;
    e = 0;
    for (int k = 7; k >= 1; k--) if (e == 0 && v >= (128 << k)) e = k;
    m = (v >> (e + 3)) % 16;
    return ~{neg, 3'(e), 4'(m)};
  endfunction

  task automatic check(string tag, logic [2:0] got, logic [2:0] exp, int at);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at sample %0d: got {oe,sd,fs}=%b expected %b", tag, at, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0; in_valid = 1'b0; in_data = '0;
    packed_mode = 1'b0; slot_count = 8'd4; word_len = 6'd8;
    active_mask = '0; compand_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // drive a stream and compare every bit against a position-based model
  task automatic scenario(logic pk, int sc, int wl, logic [127:0] act,
                          logic [127:0] cmp, int nwords, int nframes, int seed);
    int F, na, widx, starts, nsmp;
    logic pend;
    do_reset();
    @(negedge clk);
    packed_mode = pk; slot_count = 8'(sc); word_len = 6'(wl);
    active_mask = act; compand_mask = cmp; run = 1'b1;
    widx = 0;
    in_valid = (widx < nwords); in_data = wd(widx, seed);
    #1;
    F = sc * wl;
    na = 0;
    for (int s = 0; s < sc; s++) if (act[s]) na++;
    nsmp = nframes * F + 1;
    starts = 0;
    for (int i = 0; i < nsmp; i++) begin
      int r, s, b, fr, idx;
      logic eoe, esd, efs;
      logic [31:0] al;
      string tag;
      r = i % F;
      efs = pk ? ((r / wl) >= sc / 2) : (r == 0);
      eoe = 1'b0; esd = 1'b0;
      tag = pk ? "R5" : "R4";
      if (i == 0) tag = "R1";
      else begin
        fr = (i - 1) / F; r = (i - 1) % F; s = r / wl; b = r % wl;
        if (act[s]) begin
          idx = fr * na;
          for (int k = 0; k < s; k++) if (act[k]) idx++;
          eoe = 1'b1;
          al = wd(idx, seed) << (32 - wl);
          if (idx >= nwords) begin esd = 1'b0; tag = "R8"; end
          else if (cmp[s]) begin
            esd = (b < 8) ? ulaw(al[31:16])[7 - b] : 1'b0;
            tag = (fr > 0) ? "R7" : "R6";
          end else begin
            esd = al[31 - b]; tag = "R2";
          end
        end else tag = "R3";
      end
      check(tag, {sd_oe, sd_out, fs_out}, {eoe, esd, efs}, i);
      pend = in_ready && in_valid;
      @(negedge clk);
      if (pend) widx++;
      in_valid = (widx < nwords); in_data = wd(widx, seed);
      #1;
    end
    // active slot starts occurred before samples 1..nsmp
    for (int j = 0; j < nsmp; j++) if (act[(j % F) / wl] && (j % wl) == 0) starts++;
    check("R2 words taken", 3'(widx), 3'((starts < nwords) ? starts : nwords), nsmp);
    check("R8 flag", {2'b00, underflow}, {2'b00, starts > nwords}, nsmp);
    run = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", {sd_oe, sd_out, fs_out}, 3'b001, 0);
    check("R1 ready/flag", {1'b0, in_ready, underflow}, 3'b000, 0);
  endtask

  task automatic t_pulse_dense();
    scenario(1'b0, 4, 16, 128'hF, 128'h0, 64, 3, 1);
  endtask

  task automatic t_sparse_compand();
    // first active slot is 2 and is companded; slot 0 compand bit is ignored
    scenario(1'b0, 6, 8, 128'b110100, 128'b100101, 64, 3, 2);
  endtask

  task automatic t_split();
    scenario(1'b1, 4, 12, 128'hF, 128'b0010, 64, 2, 3);
  endtask

  task automatic t_starve();
    scenario(1'b0, 3, 10, 128'b111, 128'b000, 4, 3, 4);
  endtask

  task automatic t_freeze();
    logic [2:0] snap;
    do_reset();
    @(negedge clk);
    slot_count = 8'd2; word_len = 6'd8; active_mask = 128'b11;
    in_valid = 1'b1; in_data = 32'h000000A5; run = 1'b1;
    repeat (6) @(negedge clk);
    run = 1'b0;
    #1;
    snap = {sd_oe, sd_out, fs_out};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check("R9 hold", {sd_oe, sd_out, fs_out}, snap, k);
      check("R9 ready", {2'b00, in_ready}, 3'b000, k);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pulse_dense();
    t_sparse_compand();
    t_split();
    t_starve();
    t_freeze();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule